// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Transfer Link

This block joins a bus master and a bus slave that run on unrelated clocks. Each transfer is one fully interlocked four-edge request/acknowledge cycle and may be a read or a write. The master places address, direction and (for a write) data on the bus. It then waits a programmed number of its own clock cycles so that slaves can decode the address. Only after that wait does it raise request. The slave answers with acknowledge. The master drops request. The slave drops acknowledge, which closes the cycle. Each side passes the control line it receives through a two-flop synchroniser before using it.

On the user side the master takes commands over a valid/ready channel and returns one completion per command over a second valid/ready channel. A command is accepted only on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the completion has been taken. A completion is offered with `rsp_valid` and held, data unchanged, until `rsp_ready` is high on a clock edge. On the device side the slave issues single-cycle read and write strobes. For a write, acknowledge means the data has been taken. For a read, acknowledge means the returned data is valid on the bus.

Top module: `hs_link_top`

## Requirements
- R1: After reset, `cmd_ready` is high and `bus_req`, `bus_ack` and `rsp_valid` are low.
- R2: `bus_req` rises exactly SETTLE_CYC master clock edges after the edge that accepts a command. The new address is on `bus_addr` from that accepting edge onward.
- R3: From the accepting edge until `bus_ack` falls, `bus_addr` holds the accepted command's address.
- R4: Each accepted write produces exactly one `dev_wr_en` strobe, carrying the command's address and data, before `bus_ack` rises. `bus_ack` rises only while the synchronised request is high.
- R5: A read completion returns, on `rsp_rdata`, the word the device held at that address. A write completion returns zero on `rsp_rdata`.
- R6: `bus_req` falls only after `bus_ack` has been seen high. `bus_ack` falls only after `bus_req` has been seen low.
- R7: `cmd_ready` is low whenever `bus_req` or `bus_ack` is high. It does not rise again until the completion has been taken.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` stays unchanged on the next cycle.
- R9: Completions come back one per command, in command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master-side clock |
| mst_rst_n | input | 1 | Master-side asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master can accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Completion offered |
| rsp_ready | input | 1 | Completion taken |
| rsp_rdata | output | DATA_W | Read data, zero for a write completion |
| slv_clk | input | 1 | Slave-side clock |
| slv_rst_n | input | 1 | Slave-side asynchronous reset, active low |
| dev_wr_en | output | 1 | Single-cycle device write strobe |
| dev_rd_en | output | 1 | Single-cycle device read strobe |
| dev_addr | output | ADDR_W | Device address |
| dev_wdata | output | DATA_W | Device write data |
| dev_rdata | input | DATA_W | Device read data, sampled on the read strobe |
| bus_req | output | 1 | Observed bus request line |
| bus_ack | output | 1 | Observed bus acknowledge line |
| bus_addr | output | ADDR_W | Observed bus address |

## Verification
Two functions can fall in the same cycle. One is the completion stage holding a response under back-pressure. The other is a new command already waiting at the command port. To provoke this, the bench drives `rsp_ready` low on two of every three cycles while the next command is presented without a gap. The command must not be accepted until the held completion has been taken. The scoreboard then judges order and data, and the back-pressure monitor judges that the held word did not move.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_SETTLE, M_WAIT_ACK, M_WAIT_DROP, M_RESP
  } mst_state_t;

  typedef enum logic [1:0] {
    S_IDLE, S_DELAY, S_ACK
  } slv_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SETTLE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_req,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  mst_state_t        state;
  logic [CW-1:0]     cnt;
  logic              ack_s;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              req_q;
  logic              rsp_v;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
  );

  assign cmd_ready = (state == M_IDLE) && !ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= M_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      req_q   <= 1'b0;
      rsp_v   <= 1'b0;
    end else begin
      case (state)
        M_IDLE: if (cmd_valid && cmd_ready) begin
          addr_q  <= cmd_addr;
          write_q <= cmd_write;
          wdata_q <= cmd_write ? cmd_wdata : '0;
          cnt     <= CW'(SETTLE_CYC - 1);
          state   <= M_SETTLE;
        end
        M_SETTLE: if (cnt == '0) begin
          req_q <= 1'b1;
          state <= M_WAIT_ACK;
        end else begin
          cnt <= cnt - 1'b1;
        end
        M_WAIT_ACK: if (ack_s) begin
          req_q   <= 1'b0;
          rdata_q <= write_q ? '0 : bus_rdata;
          state   <= M_WAIT_DROP;
        end
        M_WAIT_DROP: if (!ack_s) begin
          rsp_v <= 1'b1;
          state <= M_RESP;
        end
        M_RESP: if (rsp_ready) begin
          rsp_v <= 1'b0;
          state <= M_IDLE;
        end
        default: state <= M_IDLE;
      endcase
    end
  end

  assign bus_addr  = addr_q;
  assign bus_write = write_q;
  assign bus_wdata = wdata_q;
  assign bus_req   = req_q;
  assign rsp_valid = rsp_v;
  assign rsp_rdata = rdata_q;

  // R2: the accepting edge never raises request at once
  a_r2_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !bus_req);
  // R3: bus fields frozen for the whole transfer
  a_r3_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != M_IDLE && $past(state) != M_IDLE) |->
      ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));
  // R6: request drops only after acknowledge was seen
  a_r6_req_fall_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(ack_s));
  // R7: no new command while request is up
  a_r7_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cmd_ready);
  // R8: completion held under back-pressure
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int ACK_EXTRA   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              dev_wr_en,
  output logic              dev_rd_en,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] dev_rdata
);
  localparam int EW = $clog2(ACK_EXTRA + 2);
  localparam logic [EW-1:0] DELAY_LOAD = EW'(ACK_EXTRA > 0 ? ACK_EXTRA - 1 : 0);

  slv_state_t        state;
  logic [EW-1:0]     cnt;
  logic              req_s;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              start;

  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_s)
  );

  assign start     = (state == S_IDLE) && req_s;
  assign dev_wr_en = start && bus_write;
  assign dev_rd_en = start && !bus_write;
  assign dev_addr  = bus_addr;
  assign dev_wdata = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_s) begin
          if (!bus_write) rdata_q <= dev_rdata;
          if (ACK_EXTRA == 0) begin
            ack_q <= 1'b1;
            state <= S_ACK;
          end else begin
            cnt   <= DELAY_LOAD;
            state <= S_DELAY;
          end
        end
        S_DELAY: if (cnt == '0) begin
          ack_q <= 1'b1;
          state <= S_ACK;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_ACK: if (!req_s) begin
          ack_q <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;

  // R4: acknowledge rises only while request is seen high
  a_r4_ack_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> req_s);
  // R4: one strobe per transfer, never both kinds
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr_en || dev_rd_en) |=> !(dev_wr_en || dev_rd_en));
  a_r4_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_wr_en, dev_rd_en}));
  // R6: acknowledge drops only after request seen low
  a_r6_ack_fall_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> !$past(req_s));
endmodule

// File: rtl/hs_link_top.sv
module hs_link_top #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SETTLE_CYC  = 2,
  parameter int ACK_EXTRA   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mst_clk,
  input  logic              mst_rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              slv_clk,
  input  logic              slv_rst_n,
  output logic              dev_wr_en,
  output logic              dev_rd_en,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              bus_req,
  output logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr
);
  logic              bus_write;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;

  hs_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_master (
    .clk(mst_clk), .rst_n(mst_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  hs_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ACK_EXTRA(ACK_EXTRA), .SYNC_STAGES(SYNC_STAGES)
  ) u_slave (
    .clk(slv_clk), .rst_n(slv_rst_n),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .dev_wr_en(dev_wr_en), .dev_rd_en(dev_rd_en), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );
endmodule

// File: tb/tb_hs_link_top.sv
module tb_hs_link_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int SETTLE = 2;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } item_t;

  logic mst_clk = 1'b0, slv_clk = 1'b0;
  logic mst_rst_n = 1'b0, slv_rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, dev_wr_en, dev_rd_en, bus_req, bus_ack;
  logic [DW-1:0] rsp_rdata, dev_wdata, dev_rdata;
  logic [AW-1:0] dev_addr, bus_addr;

  logic [DW-1:0] mem   [16];
  logic [DW-1:0] model [16];
  item_t exp_q[$];
  int checks = 0, errors = 0;
  int wr_total = 0, writes_done = 0, n_resp = 0;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;
  int stall_mode = 0;
  int tick = 0;

  always #4 mst_clk = ~mst_clk;
  always #5.5 slv_clk = ~slv_clk;

  hs_link_top #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(SETTLE), .ACK_EXTRA(1)) dut (
    .mst_clk(mst_clk), .mst_rst_n(mst_rst_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .slv_clk(slv_clk), .slv_rst_n(slv_rst_n),
    .dev_wr_en(dev_wr_en), .dev_rd_en(dev_rd_en), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .bus_req(bus_req),
    .bus_ack(bus_ack), .bus_addr(bus_addr)
  );

  // device model
  assign dev_rdata = mem[dev_addr];
  always @(posedge slv_clk) begin
    if (!slv_rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'h1000 + 16'(i) * 16'h0101;
    end else if (dev_wr_en) begin
      mem[dev_addr] <= dev_wdata;
    end
  end

  always @(negedge slv_clk) begin
    if (slv_rst_n && dev_wr_en) begin
      wr_total++;
      last_wa = dev_addr;
      last_wd = dev_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // completion back-pressure pattern
  initial forever begin
    @(posedge mst_clk); #1;
    rsp_ready = (stall_mode == 0) || (tick % 3 == 2);
    tick++;
  end

  // driver: pushes expected item, then offers the command until taken
  task automatic do_cmd(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    it.wr = wr;
    it.a  = a;
    it.d  = wr ? d : model[a];
    if (wr) model[a] = d;
    exp_q.push_back(it);
    @(posedge mst_clk); #1;
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge mst_clk);
    while (!cmd_ready) @(negedge mst_clk);
    @(posedge mst_clk); #1;
    cmd_valid = 1'b0;
  endtask

  // monitor: scoreboard plus handshake-ordering checks
  int since_acc = -1;
  bit req_seen = 0, in_xfer = 0, bad_r3 = 0, bad_r6 = 0, bad_r7 = 0;
  logic prev_req = 0, prev_ack = 0, prev_hold = 0;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] prev_data;
  always @(negedge mst_clk) begin
    if (mst_rst_n) begin
      if (prev_hold) begin
        chk(rsp_valid && rsp_rdata == prev_data, "R8 held completion", int'(rsp_rdata), int'(prev_data));
      end
      prev_hold = rsp_valid && !rsp_ready;
      prev_data = rsp_rdata;

      if (prev_req && !bus_req && !prev_ack) bad_r6 = 1;
      if (prev_ack && !bus_ack && bus_req) bad_r6 = 1;
      if ((bus_req || bus_ack) && cmd_ready) bad_r7 = 1;
      if (in_xfer && since_acc >= 1 && bus_addr != acc_addr) bad_r3 = 1;
      if (in_xfer && prev_ack && !bus_ack) in_xfer = 0;

      if (cmd_valid && cmd_ready) begin
        since_acc = 0; req_seen = 0; in_xfer = 1; acc_addr = cmd_addr;
      end else if (since_acc >= 0) begin
        since_acc++;
        if (bus_req && !req_seen) begin
          req_seen = 1;
          chk(since_acc == SETTLE + 1, "R2 request after settle", since_acc, SETTLE + 1);
        end
      end

      if (rsp_valid && rsp_ready) begin
        item_t it;
        n_resp++;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected completion", n_resp, 0);
        end else begin
          it = exp_q.pop_front();
          if (it.wr) begin
            writes_done++;
            chk(rsp_rdata == '0, "R5 write completion zero", int'(rsp_rdata), 0);
            chk(wr_total == writes_done, "R4 one write strobe", wr_total, writes_done);
            chk(last_wa == it.a && last_wd == it.d, "R4 strobe addr/data",
                int'({last_wa, last_wd}), int'({it.a, it.d}));
          end else begin
            chk(rsp_rdata == it.d, "R5/R9 read data in order", int'(rsp_rdata), int'(it.d));
          end
        end
        chk(!bad_r3, "R3 address stable", 0, 0);
        chk(!bad_r6, "R6 interlock order", 0, 0);
        chk(!bad_r7, "R7 ready low while busy", 0, 0);
        bad_r3 = 0; bad_r6 = 0; bad_r7 = 0;
      end
      prev_req = bus_req;
      prev_ack = bus_ack;
    end
  end

  initial begin
    repeat (100000) @(posedge mst_clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 16'h1000 + 16'(i) * 16'h0101;
    repeat (4) @(posedge slv_clk);
    #1; mst_rst_n = 1'b1; slv_rst_n = 1'b1;
    @(negedge mst_clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", int'(cmd_ready), 1);
    chk(!bus_req && !bus_ack, "R1 bus idle after reset", int'({bus_req, bus_ack}), 0);
    chk(rsp_valid == 1'b0, "R1 no completion after reset", int'(rsp_valid), 0);

    do_cmd(1, 4'd3, 16'hA5A5);
    do_cmd(1, 4'd0, 16'hFFFF);
    do_cmd(1, 4'd15, 16'h0001);
    do_cmd(0, 4'd3, '0);
    do_cmd(0, 4'd0, '0);
    do_cmd(0, 4'd15, '0);
    do_cmd(0, 4'd7, '0);
    // back-pressure with commands queued behind held completions
    stall_mode = 1;
    do_cmd(1, 4'd7, 16'h1234);
    do_cmd(0, 4'd7, '0);
    do_cmd(0, 4'd3, '0);
    do_cmd(1, 4'd3, 16'h0000);
    do_cmd(0, 4'd3, '0);
    do_cmd(0, 4'd9, '0);

    while (exp_q.size() != 0) @(negedge mst_clk);
    repeat (20) @(negedge mst_clk);
    chk(n_resp == 13, "R9 one completion per command", n_resp, 13);
    chk(!bus_req && !bus_ack && cmd_ready, "R7 idle at end", int'({bus_req, bus_ack, cmd_ready}), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule